// File: doc/BRIEF.md
# USB OTG Wrapper Interrupt Controller

This block gathers the interrupt sources that surround a USB controller core and presents them to a processor as one level-sensitive interrupt line. Sources fall into two groups. The main group holds a single bit for the core's own interrupt. The auxiliary group records three kinds of event: both edges of four OTG control outputs (VBUS drive, VBUS charge, VBUS discharge, ID pull-up), a pulsed OTG event, and a pulsed notice that the DMA-disable condition has been lifted.

Each group has four registers on a 32-bit read/write port. A raw status register holds every latched event. A masked view shows raw status ANDed with the enables. Two further registers set and clear enables. Software reads the masked view and writes the same value back to acknowledge the events it saw. It then writes an end-of-interrupt command, which drops the output for one cycle so that a downstream edge-sensitive controller sees a fresh assertion if work remains.

Register map (byte addresses): 0x00 end-of-interrupt; main group raw 0x10, masked 0x14, enable-set 0x18, enable-clear 0x1C; auxiliary group raw 0x20, masked 0x24, enable-set 0x28, enable-clear 0x2C. Any other address reads zero.

Top module: `otg_irq_wrap`

## Requirements
- R1: After reset every status and enable register reads 0 and `irq_o` is 0.
- R2: A 0-to-1 change on `otg_ctl_i[k]` sets one auxiliary status bit. The bit is 13 for k=3 (drive), 12 for k=2 (charge), 11 for k=1 (discharge) and 8 for k=0 (ID pull-up). The status register updates at the first clock edge that sees the new level.
- R3: A 1-to-0 change on `otg_ctl_i[k]` sets auxiliary bit 5 (k=3), 4 (k=2), 3 (k=1) or 0 (k=0).
- R4: If a line is high for exactly one cycle, both its rise bit and its fall bit are set.
- R5: A high cycle on `otg_evt_i` sets auxiliary bit 16. A high cycle on `dma_clr_i` sets auxiliary bit 17. A high cycle on `core_irq_i` sets main bit 0.
- R6: A write to an enable-set address enables exactly the bits written as 1; writing 0 changes nothing. Reading either the enable-set or the enable-clear address returns the current enable mask.
- R7: A write to an enable-clear address disables exactly the bits written as 1.
- R8: The masked status address reads raw status AND enable.
- R9: A write to a group's raw or masked address clears the raw bits written as 1. An event arriving in the same cycle as the clear stays set.
- R10: `irq_o` is a registered OR of both groups' masked status. It follows that status one clock later.
- R11: A write to 0x00 with bit 0 set forces `irq_o` low in the next cycle. If masked status is still pending, `irq_o` rises again in the cycle after that. A write to 0x00 with bit 0 clear has no effect.
- R12: Only the defined bits exist. These are main bit 0 and auxiliary bits 17, 16, 13, 12, 11, 8, 5, 4, 3 and 0. All other bits read 0 and cannot be enabled or set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_irq_i | input | 1 | Core interrupt request, sampled each cycle |
| otg_evt_i | input | 1 | OTG event pulse |
| dma_clr_i | input | 1 | DMA-disable-lifted pulse |
| otg_ctl_i | input | 4 | OTG control lines: [3] drive, [2] charge, [1] discharge, [0] ID pull-up |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the full auxiliary bit map. With these settings every monitored edge position, the undefined bit positions and an unmapped address are all reachable through the normal register port. The bench drives each control line on its own and all lines together. It holds a line high for a single cycle to check the paired rise and fall bits. It lines up an acknowledge write with a new event in the same cycle, and it times the one-cycle gap after end-of-interrupt against a source that is still pending.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;

    localparam int REG_W      = 32;
    localparam int N_MON      = 4;
    localparam int RISE_SHIFT = 8;

    // Byte offsets
    localparam int OFF_EOI      = 'h00;
    localparam int OFF_MAIN     = 'h10;
    localparam int OFF_AUX      = 'h20;
    localparam int SUB_RAW      = 'h0;
    localparam int SUB_MASKED   = 'h4;
    localparam int SUB_EN_SET   = 'h8;
    localparam int SUB_EN_CLR   = 'hC;

    // Auxiliary group bit positions
    localparam int BIT_OTG_EVT = 16;
    localparam int BIT_DMA_CLR = 17;

    localparam logic [REG_W-1:0] MAIN_VALID = 32'h0000_0001;
    localparam logic [REG_W-1:0] AUX_VALID  = 32'h0003_3939;

    // Control line index -> fall bit position (rise = position + RISE_SHIFT)
    function automatic int mon_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    typedef struct packed {
        logic [REG_W-1:0] raw;
        logic [REG_W-1:0] en;
    } grp_state_t;

    typedef struct packed {
        logic             irq;
        logic [N_MON-1:0] ctl;
    } top_state_t;

endpackage

// File: rtl/otg_edge_det.sv
module otg_edge_det
    import otg_irq_pkg::*;
(
    input  logic [N_MON-1:0] cur_i,
    input  logic [N_MON-1:0] prev_i,
    output logic [REG_W-1:0] evt_o
);

    always_comb begin
        evt_o = '0;
        for (int i = 0; i < N_MON; i++) begin
            evt_o[mon_pos(i) + RISE_SHIFT] = cur_i[i] & ~prev_i[i];
            evt_o[mon_pos(i)]              = ~cur_i[i] & prev_i[i];
        end
    end

endmodule

// File: rtl/otg_irq_group.sv
module otg_irq_group
    import otg_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = 32'h1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic             w1c_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] raw_o,
    output logic [REG_W-1:0] en_o,
    output logic [REG_W-1:0] masked_o
);

    grp_state_t st_d, st_q;
    logic [REG_W-1:0] evt_v;

    always_comb begin
        evt_v = evt_i & VALID;
        st_d  = st_q;
        if (set_wr) st_d.en = st_d.en | (wdata & VALID);
        if (clr_wr) st_d.en = st_d.en & ~wdata;
        st_d.raw = (st_q.raw & ~(w1c_wr ? wdata : '0)) | evt_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign en_o     = st_q.en;
    assign masked_o = st_q.raw & st_q.en;

    AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & VALID)) |=> ((raw_o & $past(evt_i & VALID)) == $past(evt_i & VALID))); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_wr && ((evt_i & wdata) == '0)) |=> ((raw_o & $past(wdata)) == '0)); // R9
    AST_SET_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !clr_wr && wdata == '0) |=> $stable(en_o)); // R6
    AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_wr) |=> ((en_o & $past(wdata)) == '0)); // R7

endmodule

// File: rtl/otg_irq_wrap.sv
module otg_irq_wrap
    import otg_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_irq_i,
    input  logic              otg_evt_i,
    input  logic              dma_clr_i,
    input  logic [N_MON-1:0]  otg_ctl_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_EOI      = ADDR_W'(OFF_EOI);
    localparam logic [ADDR_W-1:0] A_MAIN_RAW = ADDR_W'(OFF_MAIN + SUB_RAW);
    localparam logic [ADDR_W-1:0] A_MAIN_MSK = ADDR_W'(OFF_MAIN + SUB_MASKED);
    localparam logic [ADDR_W-1:0] A_MAIN_SET = ADDR_W'(OFF_MAIN + SUB_EN_SET);
    localparam logic [ADDR_W-1:0] A_MAIN_CLR = ADDR_W'(OFF_MAIN + SUB_EN_CLR);
    localparam logic [ADDR_W-1:0] A_AUX_RAW  = ADDR_W'(OFF_AUX + SUB_RAW);
    localparam logic [ADDR_W-1:0] A_AUX_MSK  = ADDR_W'(OFF_AUX + SUB_MASKED);
    localparam logic [ADDR_W-1:0] A_AUX_SET  = ADDR_W'(OFF_AUX + SUB_EN_SET);
    localparam logic [ADDR_W-1:0] A_AUX_CLR  = ADDR_W'(OFF_AUX + SUB_EN_CLR);

    top_state_t st_d, st_q;

    logic [REG_W-1:0] edge_evt, aux_evt, main_evt;
    logic [REG_W-1:0] main_raw, main_en, main_msk;
    logic [REG_W-1:0] aux_raw, aux_en, aux_msk;
    logic             eoi_wr;

    otg_edge_det u_edge (
        .cur_i  (otg_ctl_i),
        .prev_i (st_q.ctl),
        .evt_o  (edge_evt)
    );

    always_comb begin
        aux_evt = edge_evt;
        aux_evt[BIT_OTG_EVT] = otg_evt_i;
        aux_evt[BIT_DMA_CLR] = dma_clr_i;
        main_evt    = '0;
        main_evt[0] = core_irq_i;
    end

    otg_irq_group #(.VALID(MAIN_VALID)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (main_evt),
        .set_wr   (reg_wr && reg_addr == A_MAIN_SET),
        .clr_wr   (reg_wr && reg_addr == A_MAIN_CLR),
        .w1c_wr   (reg_wr && (reg_addr == A_MAIN_RAW || reg_addr == A_MAIN_MSK)),
        .wdata    (reg_wdata),
        .raw_o    (main_raw),
        .en_o     (main_en),
        .masked_o (main_msk)
    );

    otg_irq_group #(.VALID(AUX_VALID)) u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (aux_evt),
        .set_wr   (reg_wr && reg_addr == A_AUX_SET),
        .clr_wr   (reg_wr && reg_addr == A_AUX_CLR),
        .w1c_wr   (reg_wr && (reg_addr == A_AUX_RAW || reg_addr == A_AUX_MSK)),
        .wdata    (reg_wdata),
        .raw_o    (aux_raw),
        .en_o     (aux_en),
        .masked_o (aux_msk)
    );

    always_comb begin
        eoi_wr  = reg_wr && reg_addr == A_EOI && reg_wdata[0];
        st_d     = st_q;
        st_d.ctl = otg_ctl_i;
        st_d.irq = eoi_wr ? 1'b0 : ((|main_msk) | (|aux_msk));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            A_MAIN_RAW:             reg_rdata = main_raw;
            A_MAIN_MSK:             reg_rdata = main_msk;
            A_MAIN_SET, A_MAIN_CLR: reg_rdata = main_en;
            A_AUX_RAW:              reg_rdata = aux_raw;
            A_AUX_MSK:              reg_rdata = aux_msk;
            A_AUX_SET, A_AUX_CLR:   reg_rdata = aux_en;
            default:                reg_rdata = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !irq_o); // R11
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|main_raw) | (|aux_raw))); // R10

endmodule

// File: tb/otg_irq_wrap_test.sv
module otg_irq_wrap_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_irq_i = 1'b0, otg_evt_i = 1'b0, dma_clr_i = 1'b0;
    logic [3:0]  otg_ctl_i = 4'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    otg_irq_wrap uut (
        .clk(clk), .rst_n(rst_n), .core_irq_i(core_irq_i), .otg_evt_i(otg_evt_i),
        .dma_clr_i(dma_clr_i), .otg_ctl_i(otg_ctl_i), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_all();
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        foreach (v[i]) v[i] = 1'b0;
        rd(8'h10, v); check("R1 main raw", v, 0);
        rd(8'h18, v); check("R1 main enable", v, 0);
        rd(8'h20, v); check("R1 aux raw", v, 0);
        rd(8'h28, v); check("R1 aux enable", v, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        @(negedge clk); otg_ctl_i = 4'b1000;
        @(negedge clk); rd(8'h20, v); check("R2 drive rise bit13", v, 32'h2000);
        @(negedge clk); otg_ctl_i = 4'b1111;
        @(negedge clk); rd(8'h20, v); check("R2 all rises", v, 32'h3900);
        clear_all();
    endtask

    task automatic t_fall();
        logic [31:0] v;
        @(negedge clk); otg_ctl_i = 4'b0000;
        @(negedge clk); rd(8'h20, v); check("R3 all falls", v, 32'h0039);
        clear_all();
        @(negedge clk); otg_ctl_i = 4'b0110;
        @(negedge clk); otg_ctl_i = 4'b0100;
        @(negedge clk); rd(8'h20, v); check("R3 discharge fall bit3", v, 32'h1808);
        @(negedge clk); otg_ctl_i = 4'b0000;
        clear_all();
    endtask

    task automatic t_both();
        logic [31:0] v;
        @(negedge clk); otg_ctl_i = 4'b0001;
        @(negedge clk); otg_ctl_i = 4'b0000;
        @(negedge clk); rd(8'h20, v); check("R4 one-cycle pulse both edges", v, 32'h0101);
        clear_all();
    endtask

    task automatic t_pulses();
        logic [31:0] v;
        @(negedge clk); core_irq_i = 1'b1;
        @(negedge clk); core_irq_i = 1'b0;
        rd(8'h10, v); check("R5 core bit0", v, 32'h1);
        @(negedge clk); otg_evt_i = 1'b1;
        @(negedge clk); otg_evt_i = 1'b0; dma_clr_i = 1'b1;
        @(negedge clk); dma_clr_i = 1'b0;
        rd(8'h20, v); check("R5 otg and dma bits", v, 32'h30000);
        rd(8'h24, v); check("R8 masked with no enables", v, 0);
        @(negedge clk); check("R10 irq low when all disabled", {31'b0, irq_o}, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(8'h28, 32'h10000);
        rd(8'h28, v); check("R6 set readback", v, 32'h10000);
        rd(8'h2C, v); check("R6 clr-address readback", v, 32'h10000);
        check("R10 irq lags enable by a cycle", {31'b0, irq_o}, 0);
        @(negedge clk); check("R10 irq asserted", {31'b0, irq_o}, 1);
        wr(8'h28, 32'h0);
        rd(8'h28, v); check("R6 zero write keeps enables", v, 32'h10000);
        wr(8'h28, 32'h20000);
        rd(8'h28, v); check("R6 set accumulates", v, 32'h30000);
        rd(8'h24, v); check("R8 masked equals raw and en", v, 32'h30000);
        wr(8'h2C, 32'h10000);
        rd(8'h28, v); check("R7 clear one bit", v, 32'h20000);
        rd(8'h24, v); check("R8 masked after clear", v, 32'h20000);
        wr(8'h2C, 32'h20000);
        rd(8'h24, v); check("R7 masked empty", v, 0);
        @(negedge clk); check("R10 irq drops", {31'b0, irq_o}, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(8'h24, 32'h10000);
        rd(8'h20, v); check("R9 w1c via masked address", v, 32'h20000);
        @(negedge clk); otg_evt_i = 1'b1;
        @(negedge clk); otg_evt_i = 1'b0;
        rd(8'h20, v); check("R9 event relatched", v, 32'h30000);
        @(negedge clk);
        reg_addr = 8'h20; reg_wdata = 32'h30000; reg_wr = 1'b1; otg_evt_i = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; otg_evt_i = 1'b0;
        rd(8'h20, v); check("R9 same-cycle event stays", v, 32'h10000);
        clear_all();
    endtask

    task automatic t_eoi();
        logic [31:0] v;
        wr(8'h18, 32'h1);
        @(negedge clk); core_irq_i = 1'b1;
        @(negedge clk); core_irq_i = 1'b0;
        @(negedge clk); check("R11 irq before eoi", {31'b0, irq_o}, 1);
        wr(8'h00, 32'h1);
        check("R11 irq low after eoi", {31'b0, irq_o}, 0);
        @(negedge clk); check("R11 irq re-asserts", {31'b0, irq_o}, 1);
        wr(8'h00, 32'h2);
        check("R11 eoi bit0 clear ignored", {31'b0, irq_o}, 1);
        wr(8'h14, 32'h1);
        rd(8'h10, v); check("R9 main w1c", v, 0);
        @(negedge clk); check("R10 irq low after ack", {31'b0, irq_o}, 0);
        wr(8'h1C, 32'h1);
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R12 aux enable only defined bits", v, 32'h0003_3939);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); check("R12 main enable only bit0", v, 32'h1);
        rd(8'h3C, v); check("R12 unmapped reads zero", v, 0);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R7 clear all aux", v, 0);
        rd(8'h20, v); check("R12 aux raw idle", v, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-reqs actual=timeout expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_pulses();
        t_enable();
        t_w1c();
        t_eoi();
        t_unused();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule